// File: doc/BRIEF.md
# Wakeup-First Instruction Issue Queue

This block holds renamed instructions for a single execution pipeline of an out-of-order core until their operands are available, then hands them to that pipeline one per cycle. Each instruction arrives with up to two physical source tags, a ready flag per source, a branch speculation mask and an opaque payload. Writeback ports broadcast the tags of results being produced. A waiting source whose tag matches a broadcast becomes ready. A core instantiates one queue per pipeline, and all of them may issue in the same cycle.

Each cycle is resolved in a fixed order: wakeup, then selection, then insertion. A broadcast therefore takes effect before the queue picks its candidate, so an instruction whose last operand is woken is offered for issue in that same cycle. The issue outputs are combinational from the stored state and the current wakeup and kill inputs.

Every entry carries one mask bit per unresolved branch it depends on. A kill naming a branch index removes every dependent entry, including one that would have issued in that cycle. A resolve naming a branch index clears that bit in all entries, so a later kill of a reused index spares them.

Top module: `wakeup_issue_queue`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `full` and `iss_valid` are 0.
- R2: A waiting source becomes ready when any valid writeback lane carries its tag (lane k uses bits `wb_tags[k*TAGW +: TAGW]`). Once set, readiness persists until the entry leaves.
- R3: An entry whose last missing operand is broadcast in cycle N is offered on `iss_valid`/`iss_data` in cycle N.
- R4: An instruction presented on `ins_valid` in cycle N is never offered in cycle N. A broadcast in cycle N that matches one of its sources still marks that source ready.
- R5: When several entries are ready, the one inserted earliest is offered.
- R6: `full` is 1 exactly when all DEPTH entries are occupied. An `ins_valid` seen while `full` is 1 is dropped and never issues.
- R7: With `kill_valid`, every entry whose mask bit `kill_idx` is set is removed in that cycle and not offered, even if a broadcast in that cycle would have made it ready. An incoming instruction with that bit set is dropped.
- R8: With `resolve_valid`, bit `resolve_idx` is cleared in every stored and incoming mask. A later kill of that index spares those entries. `iss_mask` shows the issuing entry's mask as held at the start of the cycle.
- R9: An offered entry leaves the queue at the end of that cycle and is never offered again. Its slot becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction presented for insertion |
| ins_tag_a | input | TAGW | First source physical tag |
| ins_rdy_a | input | 1 | First source already available |
| ins_tag_b | input | TAGW | Second source physical tag |
| ins_rdy_b | input | 1 | Second source already available |
| ins_mask | input | BRW | Branch dependence mask |
| ins_data | input | PW | Opaque payload |
| full | output | 1 | No free entry, insertion refused |
| wb_valid | input | NWB | Per-lane writeback broadcast valid |
| wb_tags | input | NWB*TAGW | Per-lane broadcast tags |
| kill_valid | input | 1 | Squash dependents of a branch |
| kill_idx | input | BIW | Branch index to squash |
| resolve_valid | input | 1 | Branch resolved correctly |
| resolve_idx | input | BIW | Branch index to clear |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_data | output | PW | Payload of the issuing entry |
| iss_mask | output | BRW | Mask of the issuing entry |

## Verification
The sharpest corner is a broadcast that completes an entry. If issue were evaluated before wakeup, `iss_valid` would rise one cycle late. The same cycle also combines a broadcast with a kill: a design that let wakeup win would issue a squashed instruction. Insertion is probed with a broadcast matching the incoming source, which a design that ignores it would leave waiting forever, and with a kill matching the incoming mask.

Age order is checked with several entries woken together out of order. Resolve is checked by killing a reused index after clearing it. A full queue receives an extra instruction that must never surface. A long random run against an independent model in the bench covers mixed interleavings.

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue #(
  parameter int DEPTH = 8,
  parameter int TAGW  = 6,
  parameter int BRW   = 4,
  parameter int NWB   = 2,
  parameter int PW    = 8,
  parameter int BIW   = $clog2(BRW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  input  logic [TAGW-1:0]     ins_tag_a,
  input  logic                ins_rdy_a,
  input  logic [TAGW-1:0]     ins_tag_b,
  input  logic                ins_rdy_b,
  input  logic [BRW-1:0]      ins_mask,
  input  logic [PW-1:0]       ins_data,
  output logic                full,
  input  logic [NWB-1:0]      wb_valid,
  input  logic [NWB*TAGW-1:0] wb_tags,
  input  logic                kill_valid,
  input  logic [BIW-1:0]      kill_idx,
  input  logic                resolve_valid,
  input  logic [BIW-1:0]      resolve_idx,
  output logic                iss_valid,
  output logic [PW-1:0]       iss_data,
  output logic [BRW-1:0]      iss_mask
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld, rdy_a, rdy_b;
  logic [TAGW-1:0]  tag_a [DEPTH];
  logic [TAGW-1:0]  tag_b [DEPTH];
  logic [BRW-1:0]   msk   [DEPTH];
  logic [PW-1:0]    dat   [DEPTH];
  logic [DEPTH-1:0] older [DEPTH];   // older[i][j]: entry i was inserted before entry j

  logic [DEPTH-1:0] wk_a, wk_b, dead, live, req, gnt;
  logic [DEPTH-1:0] col [DEPTH];
  logic [BRW-1:0]   clr;
  logic [SW-1:0]    slot;
  logic             ins_dead, ins_wk_a, ins_wk_b, do_ins;

  function automatic logic hit(input logic [TAGW-1:0] t, input logic [NWB-1:0] v,
                               input logic [NWB*TAGW-1:0] ts);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NWB; k++)
      if (v[k] && ts[k*TAGW +: TAGW] == t) h = 1'b1;
    return h;
  endfunction

  assign full     = &vld;
  assign clr      = resolve_valid ? (BRW'(1) << resolve_idx) : '0;
  assign ins_dead = kill_valid & ins_mask[kill_idx];
  assign ins_wk_a = ins_rdy_a | hit(ins_tag_a, wb_valid, wb_tags);
  assign ins_wk_b = ins_rdy_b | hit(ins_tag_b, wb_valid, wb_tags);
  assign do_ins   = ins_valid & ~full & ~ins_dead;
  assign iss_valid = |req;

  // wakeup, then kill filter, then oldest-ready selection
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wk_a[i] = rdy_a[i] | hit(tag_a[i], wb_valid, wb_tags);
      wk_b[i] = rdy_b[i] | hit(tag_b[i], wb_valid, wb_tags);
      dead[i] = kill_valid & msk[i][kill_idx];
      live[i] = vld[i] & ~dead[i];
      req[i]  = live[i] & wk_a[i] & wk_b[i];
      for (int j = 0; j < DEPTH; j++) col[i][j] = older[j][i];
    end
    for (int i = 0; i < DEPTH; i++) gnt[i] = req[i] & ~|(req & col[i]);
  end

  always_comb begin
    iss_data = '0;
    iss_mask = '0;
    for (int i = 0; i < DEPTH; i++)
      if (gnt[i]) begin
        iss_data = iss_data | dat[i];
        iss_mask = iss_mask | msk[i];
      end
  end

  always_comb begin
    slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) slot = SW'(i);
  end

  // insertion last: uses a slot that was free at the start of the cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      rdy_a <= '0;
      rdy_b <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_a[i] <= '0;
        tag_b[i] <= '0;
        msk[i]   <= '0;
        dat[i]   <= '0;
        older[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        vld[i]   <= live[i] & ~gnt[i];
        rdy_a[i] <= wk_a[i];
        rdy_b[i] <= wk_b[i];
        msk[i]   <= msk[i] & ~clr;
      end
      if (do_ins) begin
        vld[slot]   <= 1'b1;
        rdy_a[slot] <= ins_wk_a;
        rdy_b[slot] <= ins_wk_b;
        tag_a[slot] <= ins_tag_a;
        tag_b[slot] <= ins_tag_b;
        msk[slot]   <= ins_mask & ~clr;
        dat[slot]   <= ins_data;
        for (int j = 0; j < DEPTH; j++)
          if (SW'(j) != slot) older[j][slot] <= 1'b1;
        older[slot] <= '0;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R5

  AST_NO_KILLED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && kill_valid) |-> !iss_mask[kill_idx]); // R7

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !iss_valid && !kill_valid) |=> full); // R6

  AST_ISSUED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !full && !ins_valid) |=> !full); // R9

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_RESOLVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(resolve_valid) && vld[g]) |-> !msk[g][$past(resolve_idx)]); // R8
  end
endmodule

// File: tb/sim_wakeup_issue_queue.sv
module sim_wakeup_issue_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, TAGW = 6, BRW = 4, NWB = 2, PW = 8, BIW = 2;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_rdy_a = 0, ins_rdy_b = 0;
  logic [TAGW-1:0] ins_tag_a = 0, ins_tag_b = 0;
  logic [BRW-1:0] ins_mask = 0;
  logic [PW-1:0] ins_data = 0;
  logic full;
  logic [NWB-1:0] wb_valid = 0;
  logic [NWB*TAGW-1:0] wb_tags = 0;
  logic kill_valid = 0, resolve_valid = 0;
  logic [BIW-1:0] kill_idx = 0, resolve_idx = 0;
  logic iss_valid;
  logic [PW-1:0] iss_data;
  logic [BRW-1:0] iss_mask;

  int checks = 0, fails = 0, seqn = 0;

  // independent model: entries kept with insertion sequence numbers
  logic m_v [DEPTH];
  logic m_ra [DEPTH];
  logic m_rb [DEPTH];
  logic [TAGW-1:0] m_ta [DEPTH];
  logic [TAGW-1:0] m_tb [DEPTH];
  logic [BRW-1:0] m_mk [DEPTH];
  logic [PW-1:0] m_dt [DEPTH];
  int m_sq [DEPTH];
  logic e_valid, e_full;
  logic [PW-1:0] e_data;
  logic [BRW-1:0] e_mask;
  int e_pick;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_issue_queue u0 (.*);

  function automatic logic bcast(input logic [TAGW-1:0] t);
    return (wb_valid[0] && wb_tags[TAGW-1:0] == t) || (wb_valid[1] && wb_tags[2*TAGW-1:TAGW] == t);
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_eval();
    int cnt = 0;
    int best = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i]) cnt++;
      if (m_v[i] && !(kill_valid && m_mk[i][kill_idx]) &&
          (m_ra[i] || bcast(m_ta[i])) && (m_rb[i] || bcast(m_tb[i])))
        if (best < 0 || m_sq[i] < m_sq[best]) best = i;
    end
    e_full = (cnt == DEPTH);
    e_pick = best;
    e_valid = (best >= 0);
    e_data = e_valid ? m_dt[best] : '0;
    e_mask = e_valid ? m_mk[best] : '0;
  endtask

  task automatic model_commit();
    logic [BRW-1:0] c;
    c = resolve_valid ? (BRW'(1) << resolve_idx) : '0;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i]) begin
        if ((kill_valid && m_mk[i][kill_idx]) || i == e_pick) m_v[i] = 0;
        m_ra[i] = m_ra[i] | bcast(m_ta[i]);
        m_rb[i] = m_rb[i] | bcast(m_tb[i]);
        m_mk[i] = m_mk[i] & ~c;
      end
    if (ins_valid && !e_full && !(kill_valid && ins_mask[kill_idx])) begin
      for (int i = 0; i < DEPTH; i++)
        if (!m_v[i] && i != e_pick && !(m_v[i])) begin
          m_v[i] = 1; m_ra[i] = ins_rdy_a | bcast(ins_tag_a); m_rb[i] = ins_rdy_b | bcast(ins_tag_b);
          m_ta[i] = ins_tag_a; m_tb[i] = ins_tag_b; m_mk[i] = ins_mask & ~c; m_dt[i] = ins_data;
          m_sq[i] = seqn++;
          break;
        end
    end
  endtask

  // inputs are already set at a falling edge; compare, then advance one clock
  task automatic cyc(input string rq);
    #1;
    model_eval();
    check(rq, "full", full, e_full);
    check(rq, "iss_valid", iss_valid, e_valid);
    if (e_valid) begin
      check(rq, "iss_data", iss_data, e_data);
      check(rq, "iss_mask", iss_mask, e_mask);
    end
    @(posedge clk);
    model_commit();
    @(negedge clk);
    ins_valid = 0; wb_valid = 0; kill_valid = 0; resolve_valid = 0;
  endtask

  task automatic put(input logic [PW-1:0] d, input int ta, input logic ra, input int tb,
                     input logic rb, input logic [BRW-1:0] mk);
    ins_valid = 1; ins_data = d; ins_tag_a = TAGW'(ta); ins_rdy_a = ra;
    ins_tag_b = TAGW'(tb); ins_rdy_b = rb; ins_mask = mk;
  endtask

  task automatic wake(input int t0, input logic v0, input int t1, input logic v1);
    wb_valid = {v1, v0};
    wb_tags = {TAGW'(t1), TAGW'(t0)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "full in reset", full, 0);
    check("R1", "iss_valid in reset", iss_valid, 0);
    rst_n = 1;
    @(negedge clk);
    cyc("R1");

    // R4 and R2, R3: wait on tag 5, woken, issued in the wake cycle
    put(8'h11, 5, 0, 6, 1, 4'b0000); cyc("R4");
    cyc("R2");
    wake(5, 1, 0, 0); #1;
    check("R3", "same-cycle issue valid", iss_valid, 1);
    check("R3", "same-cycle issue data", iss_data, 8'h11);
    cyc("R3");
    cyc("R9");

    // R4: already ready entry not offered while being inserted
    put(8'h22, 1, 1, 2, 1, 4'b0000); #1;
    check("R4", "no issue while inserting", iss_valid, 0);
    cyc("R4");
    cyc("R4");
    // R4: broadcast coincident with insertion marks source ready
    put(8'h23, 9, 0, 2, 1, 4'b0000); wake(9, 1, 0, 0); cyc("R4");
    #1; check("R4", "woken during insert", iss_valid, 1);
    cyc("R4");

    // R5: age order with simultaneous wakeups
    put(8'hA0, 1, 0, 0, 1, 0); cyc("R5");
    put(8'hB0, 2, 0, 0, 1, 0); cyc("R5");
    put(8'hC0, 3, 0, 0, 1, 0); cyc("R5");
    wake(3, 1, 1, 1); #1;
    check("R5", "oldest ready first", iss_data, 8'hA0);
    cyc("R5");
    #1; check("R5", "next oldest ready", iss_data, 8'hC0);
    cyc("R2");
    wake(2, 1, 0, 0); cyc("R5");

    // R7: kill beats same-cycle wakeup, and drops incoming instruction
    put(8'h55, 7, 0, 0, 1, 4'b0010); cyc("R7");
    wake(7, 1, 0, 0); kill_valid = 1; kill_idx = 1; #1;
    check("R7", "kill beats wakeup", iss_valid, 0);
    cyc("R7");
    cyc("R7");
    put(8'h56, 0, 1, 0, 1, 4'b0010); kill_valid = 1; kill_idx = 1; cyc("R7");
    #1; check("R7", "killed insert absent", iss_valid, 0);
    cyc("R7");

    // R8: resolve then kill of the same index spares the entry
    put(8'h66, 12, 0, 0, 1, 4'b0100); cyc("R8");
    resolve_valid = 1; resolve_idx = 2; cyc("R8");
    kill_valid = 1; kill_idx = 2; wake(12, 1, 0, 0); #1;
    check("R8", "survives kill after resolve", iss_valid, 1);
    check("R8", "mask bit cleared", iss_mask, 0);
    cyc("R8");

    // R6: fill, attempt overflow, drain in order
    for (int k = 0; k < DEPTH; k++) begin put(PW'(8'h80 + k), 20, 0, 0, 1, 0); cyc("R6"); end
    #1; check("R6", "full after fill", full, 1);
    put(8'hEE, 0, 1, 0, 1, 0); cyc("R6");
    for (int k = 0; k < DEPTH; k++) begin
      wake(20, 1, 0, 0); #1;
      check("R6", "drain order", iss_data, 8'h80 + k);
      cyc("R6");
    end
    #1; check("R6", "overflow never stored", iss_valid, 0);
    cyc("R9");

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      ins_valid = ($urandom % 3) != 0;
      ins_data = PW'($urandom); ins_tag_a = TAGW'($urandom % 12); ins_tag_b = TAGW'($urandom % 12);
      ins_rdy_a = ($urandom % 3) == 0; ins_rdy_b = ($urandom % 2) == 0;
      ins_mask = (($urandom % 3) == 0) ? BRW'($urandom) : '0;
      wb_valid = NWB'($urandom); wb_tags = {TAGW'($urandom % 12), TAGW'($urandom % 12)};
      kill_valid = ($urandom % 17) == 0; kill_idx = BIW'($urandom);
      resolve_valid = ($urandom % 5) == 0; resolve_idx = BIW'($urandom);
      cyc("R5");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule